// File: doc/BRIEF.md
# Dual-Mode Converter Host Interface Model

This block is a clocked, synthesizable stand-in for the digital face of an 8-bit parallel-output converter. A host controller under test sees it through active-low chip select, read and write strobes, a mode level, an open-drain ready indication, an active-low completion interrupt, a tri-stateable data bus and an active-low over-range flag. The converted code and the over-range condition are not computed here. They are taken from a sample port at the sampling instant, so the block can serve as a bus-functional target that checks host timing.

Two handshakes are offered. In read mode, one extended read (select and read both low) starts the conversion, pulls the ready line low until it completes and then presents the result. In write-read mode, a write strobe starts the conversion and its rising edge closes the upper-nibble phase. A lower-nibble phase then runs out on an internal counter. A read that arrives before that counter expires cuts the phase short and takes the result at once. All delays are counted in system-clock cycles. Every strobe is seen at a clock edge, and every output is registered, so each output moves at the first clock edge that sees the input causing it.

The shared write/ready pin is split into the `wr_n` input and the `rdy_drive_low` pull-down enable. The tri-state bus is split into `dout` and `data_oe`. An undriven mode input is modelled by `mode_drv` low.

Top module: `cvt_bus_model`

## Requirements
- R1: During and straight after reset, int_n=1, ovf_n=1, data_oe=0 and rdy_drive_low=0.
- R2: In read mode, the edge that first sees cs_n and rd_n both low starts a conversion: it samples smp_code and smp_over and sets rdy_drive_low. RD_CYC edges later, int_n goes 0, rdy_drive_low goes 0 and dout holds the sampled code. If cs_n or rd_n goes high earlier, the conversion is dropped: ready is released on the next edge and int_n does not fall.
- R3: The effective mode is mode_lvl when mode_drv=1. It is read mode (low) when mode_drv=0, whatever mode_lvl is.
- R4: In write-read mode, an edge that sees wr_n fall while cs_n is low samples the inputs (edge 0). The lower phase starts at edge max(W, HI_CYC), where W is the number of edges wr_n stays low. int_n falls LO_CYC edges after that, and dout then holds the sampled code.
- R5: In write-read mode, if cs_n and rd_n newly become both low during the lower phase, the result is transferred on that same edge: int_n goes 0 and dout holds the code. No second completion follows.
- R6: The edge that sees a rising cs_n or rising rd_n sets int_n to 1. Nothing else raises int_n.
- R7: data_oe is 1 exactly on the edges that see cs_n and rd_n both low. dout changes only when a conversion completes.
- R8: ovf_n becomes the inverse of the sampled smp_over when a conversion completes. It keeps its value at all other times. Changes on smp_code or smp_over after the sampling edge do not alter the result.
- R9: wr_n has no effect in read mode. In write-read mode, a read while idle drives the bus but starts no conversion and never pulls ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, used in write-read mode only |
| mode_lvl | input | 1 | Mode level: 1 selects write-read mode |
| mode_drv | input | 1 | 1 when the mode input is driven; 0 models the internal pull-down |
| smp_code | input | DW | Code delivered for the next sampling instant |
| smp_over | input | 1 | Over-range condition for the next sampling instant |
| rdy_drive_low | output | 1 | Open-drain enable: 1 pulls the ready line low |
| int_n | output | 1 | Completion interrupt, active low |
| ovf_n | output | 1 | Over-range flag, active low, never tri-stated |
| data_oe | output | 1 | Data bus output enable |
| dout | output | DW | Output latch driven on the data bus |

## Verification
Read-mode conversions are swept over all 256 codes, with the over-range bit derived from each code. The sample port is scrambled after the sampling edge, and the write strobe is toggled during conversion. This separates the sampling instant from later input changes and shows that write is ignored in read mode. Write-read conversions sweep the write pulse width from below to above the upper-phase time, which tells apart a lower phase started by the strobe from one held back by the counter. Early reads at every lower-phase offset show the cut-short path against normal expiry. Aborted reads, an undriven mode pin, a select-only interrupt release and idle reads in write-read mode cover the paths that must not start or end a conversion.

// File: rtl/cvt_pkg.sv
`timescale 1ns/1ps
package cvt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RCONV = 2'd1,
    ST_WHI   = 2'd2,
    ST_WLO   = 2'd3
  } cvt_state_t;

  function automatic int cvt_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/cvt_pin_prev.sv
`timescale 1ns/1ps
// Registers the previous level of each strobe so the top can form edges.
module cvt_pin_prev #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_o[g] <= 1'b1;
      else     prev_o[g] <= pin_i[g];
    end
  end
endmodule

// File: rtl/cvt_phase_timer.sv
`timescale 1ns/1ps
// Loadable down-counter that stops at zero.
module cvt_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          en,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (en && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/cvt_bus_model.sv
`timescale 1ns/1ps
module cvt_bus_model
  import cvt_pkg::*;
#(
  parameter int DW     = 8,
  parameter int HI_CYC = 50,
  parameter int LO_CYC = 76,
  parameter int RD_CYC = 140
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          mode_lvl,
  input  logic          mode_drv,
  input  logic [DW-1:0] smp_code,
  input  logic          smp_over,
  output logic          rdy_drive_low,
  output logic          int_n,
  output logic          ovf_n,
  output logic          data_oe,
  output logic [DW-1:0] dout
);
  localparam int NW   = DW / 2;
  localparam int MAXC = cvt_max3(HI_CYC, LO_CYC, RD_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  // Strobe history: {select-and-read, write, read, select}
  logic [3:0] pins, prev;
  assign pins = {cs_n | rd_n, wr_n, rd_n, cs_n};

  cvt_pin_prev #(.N(4)) u_prev (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pins),
    .prev_o (prev)
  );

  logic sel_fall, wr_fall, rd_rise, cs_rise, mode_wr;
  assign sel_fall = prev[3] & ~pins[3];
  assign wr_fall  = prev[2] & ~pins[2];
  assign rd_rise  = ~prev[1] & pins[1];
  assign cs_rise  = ~prev[0] & pins[0];
  assign mode_wr  = mode_drv & mode_lvl;   // undriven pin reads low

  cvt_state_t    st, st_d;
  logic          t_load, t_en, t_zero;
  logic [CW-1:0] t_val;
  logic          cap, hi_take, finish, rdy_set, rdy_clr;
  logic [DW-1:0] cap_code;
  logic          cap_over;
  logic [DW-NW-1:0] hi_nib;

  cvt_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .en       (t_en),
    .zero     (t_zero)
  );

  always_comb begin
    st_d    = st;
    t_load  = 1'b0;
    t_val   = '0;
    t_en    = 1'b0;
    cap     = 1'b0;
    hi_take = 1'b0;
    finish  = 1'b0;
    rdy_set = 1'b0;
    rdy_clr = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (!mode_wr && sel_fall) begin
          st_d    = ST_RCONV;
          t_load  = 1'b1;
          t_val   = CW'(RD_CYC - 1);
          cap     = 1'b1;
          rdy_set = 1'b1;
        end else if (mode_wr && wr_fall && !cs_n) begin
          st_d   = ST_WHI;
          t_load = 1'b1;
          t_val  = CW'(HI_CYC - 1);
          cap    = 1'b1;
        end
      end
      ST_RCONV: begin
        if (cs_n || rd_n) begin
          st_d    = ST_IDLE;
          rdy_clr = 1'b1;
        end else if (t_zero) begin
          st_d    = ST_IDLE;
          finish  = 1'b1;
          rdy_clr = 1'b1;
        end else begin
          t_en = 1'b1;
        end
      end
      ST_WHI: begin
        if (wr_n && t_zero) begin
          st_d    = ST_WLO;
          hi_take = 1'b1;
          t_load  = 1'b1;
          t_val   = CW'(LO_CYC - 1);
        end else begin
          t_en = 1'b1;
        end
      end
      ST_WLO: begin
        if (sel_fall || t_zero) begin
          st_d   = ST_IDLE;
          finish = 1'b1;
        end else begin
          t_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      cap_code      <= '0;
      cap_over      <= 1'b0;
      hi_nib        <= '0;
      dout          <= '0;
      ovf_n         <= 1'b1;
      int_n         <= 1'b1;
      rdy_drive_low <= 1'b0;
      data_oe       <= 1'b0;
    end else begin
      st      <= st_d;
      data_oe <= ~cs_n & ~rd_n;
      if (cap) begin
        cap_code <= smp_code;
        cap_over <= smp_over;
      end
      if (hi_take) hi_nib <= cap_code[DW-1:NW];
      if (finish) begin
        dout  <= (st == ST_WLO) ? {hi_nib, cap_code[NW-1:0]} : cap_code;
        ovf_n <= ~cap_over;
        int_n <= 1'b0;
      end else if (cs_rise || rd_rise) begin
        int_n <= 1'b1;
      end
      if (rdy_set)      rdy_drive_low <= 1'b1;
      else if (rdy_clr) rdy_drive_low <= 1'b0;
    end
  end
endmodule

// File: rtl/cvt_bus_model_chk.sv
`timescale 1ns/1ps
module cvt_bus_model_chk
  import cvt_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          rd_n,
  input logic          int_n,
  input logic          ovf_n,
  input logic          data_oe,
  input logic          rdy_drive_low,
  input logic [DW-1:0] dout,
  input cvt_state_t    st
);
  p_bus_drive_r7: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> ($past(cs_n) == 1'b0 && $past(rd_n) == 1'b0));

  p_dout_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> !int_n);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(ovf_n) |-> !int_n);

  p_int_release_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(int_n) |-> (($past(cs_n) && !$past(cs_n, 2)) || ($past(rd_n) && !$past(rd_n, 2))));

  p_ready_idle_wr_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WHI || st == ST_WLO) |-> !rdy_drive_low);
endmodule

bind cvt_bus_model cvt_bus_model_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cs_n          (cs_n),
  .rd_n          (rd_n),
  .int_n         (int_n),
  .ovf_n         (ovf_n),
  .data_oe       (data_oe),
  .rdy_drive_low (rdy_drive_low),
  .dout          (dout),
  .st            (st)
);

// File: tb/cvt_bus_model_test.sv
`timescale 1ns/1ps
module cvt_bus_model_test;
  localparam int HI = 3;
  localparam int LO = 4;
  localparam int RD = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic mode_lvl = 1'b0, mode_drv = 1'b1;
  logic [7:0] smp_code = '0;
  logic smp_over = 1'b0;
  logic rdy, int_n, ovf_n, data_oe;
  logic [7:0] dout;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  cvt_bus_model #(.DW(8), .HI_CYC(HI), .LO_CYC(LO), .RD_CYC(RD)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .mode_lvl(mode_lvl), .mode_drv(mode_drv), .smp_code(smp_code), .smp_over(smp_over),
    .rdy_drive_low(rdy), .int_n(int_n), .ovf_n(ovf_n), .data_oe(data_oe), .dout(dout)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Read-mode conversion; tag names the requirement under test
  task automatic read_conv(input logic [7:0] code, input logic ov, input string tag);
    logic prev_ovf;
    prev_ovf = ovf_n;
    smp_code = code; smp_over = ov;
    cs_n = 1'b0; rd_n = 1'b0;
    step();
    check({tag, " ready pulled low"}, rdy, 1);
    smp_code = ~code; smp_over = ~ov;
    for (int i = 1; i < RD; i++) begin
      wr_n = i[0];  // R9: write toggles ignored in read mode
      step();
      check({tag, " int held high"}, int_n, 1);
      check("R8 ovf held mid-conversion", ovf_n, prev_ovf);
    end
    step();
    check({tag, " int low at end"}, int_n, 0);
    check({tag, " ready released"}, rdy, 0);
    check({tag, " R8 result code"}, dout, code);
    check("R8 ovf at end", ovf_n, !ov);
    check("R7 bus driven", data_oe, 1);
    rd_n = 1'b1; cs_n = 1'b1; wr_n = 1'b1;
    step();
    check("R6 int release on read rise", int_n, 1);
    check("R7 bus released", data_oe, 0);
  endtask

  // Write-read conversion with write pulse of w edges
  task automatic write_conv(input logic [7:0] code, input logic ov, input int w, input bit via_cs);
    int t;
    t = ((w > HI) ? w : HI) + LO;
    smp_code = code; smp_over = ov;
    cs_n = 1'b0; wr_n = 1'b0;
    step();
    check("R9 no ready in write mode", rdy, 0);
    smp_code = ~code; smp_over = ~ov;
    for (int n = 1; n <= t; n++) begin
      wr_n = (n >= w);
      step();
      check("R4 int timing", int_n, (n == t) ? 0 : 1);
    end
    check("R4 result code", dout, code);
    check("R8 ovf write mode", ovf_n, !ov);
    if (via_cs) begin
      cs_n = 1'b1;
      step();
      check("R6 int release on select rise", int_n, 1);
      check("R7 dout kept", dout, code);
    end else begin
      rd_n = 1'b0;
      step();
      check("R7 bus driven on read", data_oe, 1);
      check("R7 bus data", dout, code);
      rd_n = 1'b1; cs_n = 1'b1;
      step();
      check("R6 int release after read", int_n, 1);
    end
  endtask

  // Early read at edge r (W=1) inside the lower phase
  task automatic early_read(input logic [7:0] code, input int r);
    smp_code = code; smp_over = 1'b0;
    cs_n = 1'b0; wr_n = 1'b0;
    step();
    smp_code = ~code;
    for (int n = 1; n <= r; n++) begin
      wr_n = 1'b1;
      if (n == r) rd_n = 1'b0;
      step();
      check("R5 int at early read", int_n, (n == r) ? 0 : 1);
    end
    check("R5 early data", dout, code);
    check("R5 bus driven", data_oe, 1);
    rd_n = 1'b1; cs_n = 1'b1;
    step();
    check("R5 int released", int_n, 1);
    for (int k = 0; k < LO + 1; k++) begin
      step();
      check("R5 no second completion", int_n, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) step();
    check("R1 int_n reset", int_n, 1);
    check("R1 ovf_n reset", ovf_n, 1);
    check("R1 data_oe reset", data_oe, 0);
    check("R1 ready reset", rdy, 0);
    rst = 1'b0;
    step();
    check("R1 int_n after reset", int_n, 1);
    check("R1 data_oe after reset", data_oe, 0);

    // R2: read-mode sweep over every code
    mode_drv = 1'b1; mode_lvl = 1'b0;
    for (int c = 0; c < 256; c++) begin
      read_conv(8'(c), c[7] ^ c[0], "R2");
      step();
    end

    // R2: aborted read
    cs_n = 1'b0; rd_n = 1'b0;
    step();
    check("R2 abort ready low", rdy, 1);
    step(); step();
    rd_n = 1'b1;
    step();
    check("R2 abort ready released", rdy, 0);
    cs_n = 1'b1;
    for (int k = 0; k < RD + 2; k++) begin
      step();
      check("R2 abort no int", int_n, 1);
    end

    // R4: write-read sweep over pulse widths
    mode_lvl = 1'b1;
    for (int w = 1; w <= 6; w++) begin
      for (int k = 0; k < 16; k++) begin
        write_conv(8'((k * 17) ^ (w * 5)), k[0], w, k == 3);
        step();
      end
    end

    // R5: early read at every lower-phase offset
    for (int r = HI + 1; r < HI + LO; r++) begin
      early_read(8'(8'h3C + r), r);
      step();
    end

    // R9: idle read in write-read mode
    cs_n = 1'b0; rd_n = 1'b0;
    step();
    check("R9 idle read drives bus", data_oe, 1);
    for (int k = 0; k < RD + 2; k++) begin
      step();
      check("R9 idle read no ready", rdy, 0);
      check("R9 idle read no int", int_n, 1);
    end
    cs_n = 1'b1; rd_n = 1'b1;
    step();

    // R3: undriven mode pin reads low even with level high
    mode_drv = 1'b0; mode_lvl = 1'b1;
    cs_n = 1'b0; wr_n = 1'b0;
    step();
    wr_n = 1'b1;
    for (int k = 0; k < HI + LO + 2; k++) begin
      step();
      check("R3 write ignored when undriven", int_n, 1);
    end
    cs_n = 1'b1;
    step();
    read_conv(8'hA5, 1'b1, "R3");

    summary();
    $finish;
  end
endmodule